// File: doc/BRIEF.md
# Data Cache Write-Through Store Path with Line Zeroing

This block is the write side of a data cache that sends every store straight through to memory over a pipelined bus. The bus has a cycle signal, a strobe, a stall and an acknowledge. An ordinary store carries one 8-byte doubleword. The bus address counts doublewords, not bytes. When a store arrives while a bus cycle is already open, it can ride in that cycle if it lies in the same set-sized region of memory as the stores in flight. Stores in the same region have the same tag, which is the address bits above the set index and the line offset.

The block also handles a line-zeroing request. It is sequenced like a line refill running in the write direction: one write of all-zero data per doubleword of the line, every byte lane enabled, starting at the line base. If the line is resident in the cache, each beat also pulses a write strobe for the matching cache row so that the cached copy is cleared too.

A line-zeroing request is never folded into an open batch of stores, even when its tag matches. It waits until that batch has fully drained and then opens a bus cycle of its own. The same holds for a store whose tag differs from the open batch.

Top module: `dcs_store_path`

## Requirements
- R1: While reset is high, and after it until a request is accepted, `wb_cyc` and `wb_stb` are low and `req_ready` is high.
- R2: An accepted store produces exactly one bus write with `wb_we` high. The write carries the request's doubleword address on `wb_adr`, its data on `wb_dat` and its byte enables on `wb_sel` (bit b enables bits 8b+7..8b). Address, data and enables stay stable while `wb_stall` holds the beat.
- R3: While a store batch is open, a store whose tag (`req_adr[ADDR_W-1:LINE_BITS+SET_BITS]`) equals the batch tag is accepted into the same bus cycle. `wb_cyc` does not drop between the two stores.
- R4: While a store batch is open, a store with a different tag sees `req_ready` low until the batch has drained. It is then issued in a new bus cycle.
- R5: While a store batch is open, a line-zeroing request sees `req_ready` low, even when its tag equals the batch tag. It is then started in a new bus cycle.
- R6: A line-zeroing request issues 2^LINE_BITS writes. Their addresses are the request address with its low LINE_BITS cleared, plus 0, 1, 2 and so on in order. Every write carries zero data and has all byte enables set.
- R7: A line-zeroing sequence ends only after all of its writes have been acknowledged. `req_ready` stays low until then.
- R8: During line zeroing with `req_hit` high, `cwr_en` pulses once for each accepted bus beat. `cwr_row` equals the low LINE_BITS+SET_BITS bits of that beat's address. With `req_hit` low, `cwr_en` stays low.
- R9: `wb_cyc` stays high while any issued write is unacknowledged. It falls in the cycle after the last acknowledge, provided no joinable store is queued.
- R10: In a store batch, the number of stores that are issued but unacknowledged, plus any store waiting to issue, never exceeds MAX_OUT. Further stores see `req_ready` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_zero | input | 1 | Request is a line-zeroing operation |
| req_hit | input | 1 | Addressed line is resident in the cache (line zeroing only) |
| req_adr | input | ADDR_W | Doubleword address of the request |
| req_data | input | 64 | Store data |
| req_sel | input | 8 | Store byte enables |
| req_ready | output | 1 | Request accepted at this edge when valid |
| wb_cyc | output | 1 | Bus cycle open |
| wb_stb | output | 1 | Bus beat offered |
| wb_we | output | 1 | Write direction |
| wb_adr | output | ADDR_W | Doubleword bus address |
| wb_dat | output | 64 | Write data |
| wb_sel | output | 8 | Byte enables |
| wb_stall | input | 1 | Bus refuses the offered beat |
| wb_ack | input | 1 | One earlier beat completed |
| cwr_en | output | 1 | Clear one cache row |
| cwr_row | output | LINE_BITS+SET_BITS | Cache row to clear |

## Verification
The assertions rely on the bus acknowledging only beats that it has already taken, at most one per cycle, so the count of outstanding writes kept from the port handshakes never goes negative. They also rely on `req_hit` describing the line that belongs to the zeroing request. The bench's bus model sends an acknowledge only while its own count of accepted beats is above zero, and it can withhold acknowledges or force stalls. Requests are always driven in the half-cycle before the sampling edge and removed once they are taken.

// File: rtl/dcs_pkg.sv
package dcs_pkg;

    localparam int unsigned DW_BITS  = 64;
    localparam int unsigned SEL_BITS = DW_BITS / 8;

    typedef logic [DW_BITS-1:0]  dword_t;
    typedef logic [SEL_BITS-1:0] bsel_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_STORE = 2'd1,
        ST_ZERO  = 2'd2
    } dcs_state_e;

    // One bus beat as seen by the output mux
    typedef struct packed {
        dword_t dat;
        bsel_t  sel;
    } beat_t;

    // A request may join an open batch only when it is a plain store,
    // its tag matches and the batch still has room.
    function automatic logic join_allowed(input logic is_zero,
                                          input logic tag_eq,
                                          input logic room);
        return !is_zero && tag_eq && room;
    endfunction

endpackage

// File: rtl/dcs_join_ctl.sv
module dcs_join_ctl
    import dcs_pkg::*;
#(
    parameter int unsigned TAG_W = 4
) (
    input  dcs_state_e        st,
    input  logic              req_valid,
    input  logic              req_zero,
    input  logic [TAG_W-1:0]  req_tag,
    input  logic [TAG_W-1:0]  open_tag,
    input  logic              slot_room,
    output logic              req_ready,
    output logic              start_store,
    output logic              start_zero,
    output logic              append
);

    always_comb begin
        unique case (st)
            ST_IDLE:  req_ready = 1'b1;
            ST_STORE: req_ready = join_allowed(req_zero, req_tag == open_tag, slot_room);
            default:  req_ready = 1'b0;
        endcase
        start_store = (st == ST_IDLE)  && req_valid && !req_zero;
        start_zero  = (st == ST_IDLE)  && req_valid &&  req_zero;
        append      = (st == ST_STORE) && req_valid &&  req_ready;
    end

endmodule

// File: rtl/dcs_store_slot.sv
module dcs_store_slot
    import dcs_pkg::*;
#(
    parameter int unsigned ADDR_W  = 10,
    parameter int unsigned MAX_OUT = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] ld_adr,
    input  beat_t             ld_beat,
    input  logic              bus_stall,
    input  logic              bus_ack,
    output logic              slot_valid,
    output logic [ADDR_W-1:0] slot_adr,
    output beat_t             slot_beat,
    output logic              room,
    output logic              drained_next
);

    localparam int unsigned OUT_W = $clog2(MAX_OUT + 1);
    localparam int unsigned CW    = OUT_W + 1;

    logic [OUT_W-1:0] out_cnt;
    logic [OUT_W-1:0] out_next;
    logic             issue;
    logic [CW-1:0]    inflight;

    assign issue    = slot_valid && !bus_stall;
    assign inflight = CW'(out_cnt) + CW'(slot_valid) - CW'(bus_ack);
    assign room     = (!slot_valid || !bus_stall) && (inflight < CW'(MAX_OUT));
    assign out_next = out_cnt + OUT_W'(issue) - OUT_W'(bus_ack);
    assign drained_next = !load && !(slot_valid && !issue) && (out_next == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_cnt    <= '0;
            slot_valid <= 1'b0;
            slot_adr   <= '0;
            slot_beat  <= '0;
        end else begin
            out_cnt <= out_next;
            if (load) begin
                slot_valid <= 1'b1;
                slot_adr   <= ld_adr;
                slot_beat  <= ld_beat;
            end else if (issue) begin
                slot_valid <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/dcs_zero_seq.sv
module dcs_zero_seq
    import dcs_pkg::*;
#(
    parameter int unsigned ADDR_W    = 10,
    parameter int unsigned LINE_BITS = 3
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        start,
    input  logic [ADDR_W-LINE_BITS-1:0] start_base,
    input  logic                        start_hit,
    input  logic                        active,
    input  logic                        bus_stall,
    input  logic                        bus_ack,
    output logic                        z_stb,
    output logic [ADDR_W-1:0]           z_adr,
    output logic                        cwr_en,
    output logic                        done
);

    localparam int unsigned LINE_DW = 1 << LINE_BITS;
    localparam int unsigned CNT_W   = LINE_BITS + 1;
    localparam int unsigned BASE_W  = ADDR_W - LINE_BITS;

    logic [BASE_W-1:0] base_r;
    logic              hit_r;
    logic [CNT_W-1:0]  iss_cnt;
    logic [CNT_W-1:0]  ack_cnt;

    assign z_stb  = active && (iss_cnt < CNT_W'(LINE_DW));
    assign z_adr  = {base_r, iss_cnt[LINE_BITS-1:0]};
    assign cwr_en = z_stb && !bus_stall && hit_r;
    assign done   = active && bus_ack && (ack_cnt == CNT_W'(LINE_DW - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            base_r  <= '0;
            hit_r   <= 1'b0;
            iss_cnt <= '0;
            ack_cnt <= '0;
        end else if (start) begin
            base_r  <= start_base;
            hit_r   <= start_hit;
            iss_cnt <= '0;
            ack_cnt <= '0;
        end else if (active) begin
            if (z_stb && !bus_stall) iss_cnt <= iss_cnt + 1'b1;
            if (bus_ack)             ack_cnt <= ack_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/dcs_store_path.sv
module dcs_store_path
    import dcs_pkg::*;
#(
    parameter int unsigned ADDR_W    = 10,
    parameter int unsigned LINE_BITS = 3,
    parameter int unsigned SET_BITS  = 3,
    parameter int unsigned MAX_OUT   = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          req_valid,
    input  logic                          req_zero,
    input  logic                          req_hit,
    input  logic [ADDR_W-1:0]             req_adr,
    input  logic [63:0]                   req_data,
    input  logic [7:0]                    req_sel,
    output logic                          req_ready,
    output logic                          wb_cyc,
    output logic                          wb_stb,
    output logic                          wb_we,
    output logic [ADDR_W-1:0]             wb_adr,
    output logic [63:0]                   wb_dat,
    output logic [7:0]                    wb_sel,
    input  logic                          wb_stall,
    input  logic                          wb_ack,
    output logic                          cwr_en,
    output logic [LINE_BITS+SET_BITS-1:0] cwr_row
);

    localparam int unsigned TAG_LSB = LINE_BITS + SET_BITS;
    localparam int unsigned TAG_W   = ADDR_W - TAG_LSB;

    dcs_state_e        st, st_next;
    logic [TAG_W-1:0]  open_tag;
    logic [TAG_W-1:0]  req_tag;

    logic              start_store, start_zero, append;
    logic              slot_valid, slot_room, drained_next;
    logic [ADDR_W-1:0] slot_adr;
    beat_t             slot_beat;
    beat_t             req_beat;

    logic              z_stb, z_done, z_active;
    logic [ADDR_W-1:0] z_adr;

    assign req_tag  = req_adr[ADDR_W-1:TAG_LSB];
    assign req_beat = '{dat: req_data, sel: req_sel};
    assign z_active = (st == ST_ZERO);

    dcs_join_ctl #(.TAG_W(TAG_W)) join_i (
        .st          (st),
        .req_valid   (req_valid),
        .req_zero    (req_zero),
        .req_tag     (req_tag),
        .open_tag    (open_tag),
        .slot_room   (slot_room),
        .req_ready   (req_ready),
        .start_store (start_store),
        .start_zero  (start_zero),
        .append      (append)
    );

    dcs_store_slot #(.ADDR_W(ADDR_W), .MAX_OUT(MAX_OUT)) slot_i (
        .clk          (clk),
        .rst          (rst),
        .load         (start_store || append),
        .ld_adr       (req_adr),
        .ld_beat      (req_beat),
        .bus_stall    (wb_stall),
        .bus_ack      (wb_ack && (st == ST_STORE)),
        .slot_valid   (slot_valid),
        .slot_adr     (slot_adr),
        .slot_beat    (slot_beat),
        .room         (slot_room),
        .drained_next (drained_next)
    );

    dcs_zero_seq #(.ADDR_W(ADDR_W), .LINE_BITS(LINE_BITS)) zero_i (
        .clk        (clk),
        .rst        (rst),
        .start      (start_zero),
        .start_base (req_adr[ADDR_W-1:LINE_BITS]),
        .start_hit  (req_hit),
        .active     (z_active),
        .bus_stall  (wb_stall),
        .bus_ack    (wb_ack),
        .z_stb      (z_stb),
        .z_adr      (z_adr),
        .cwr_en     (cwr_en),
        .done       (z_done)
    );

    always_comb begin
        st_next = st;
        unique case (st)
            ST_IDLE: begin
                if (start_zero)       st_next = ST_ZERO;
                else if (start_store) st_next = ST_STORE;
            end
            ST_STORE: if (drained_next) st_next = ST_IDLE;
            ST_ZERO:  if (z_done)       st_next = ST_IDLE;
            default:  st_next = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            open_tag <= '0;
        end else begin
            st <= st_next;
            if (start_store) open_tag <= req_tag;
        end
    end

    always_comb begin
        wb_cyc = (st != ST_IDLE);
        wb_we  = wb_cyc;
        if (st == ST_ZERO) begin
            wb_stb = z_stb;
            wb_adr = z_adr;
            wb_dat = '0;
            wb_sel = '1;
        end else begin
            wb_stb = slot_valid;
            wb_adr = slot_adr;
            wb_dat = slot_beat.dat;
            wb_sel = slot_beat.sel;
        end
    end

    assign cwr_row = z_adr[TAG_LSB-1:0];

endmodule

// File: rtl/dcs_store_path_chk.sv
module dcs_store_path_chk
    import dcs_pkg::*;
#(
    parameter int unsigned ADDR_W  = 10,
    parameter int unsigned MAX_OUT = 4
) (
    input logic              clk,
    input logic              rst,
    input dcs_state_e        st,
    input logic              req_zero,
    input logic              req_ready,
    input logic              wb_cyc,
    input logic              wb_stb,
    input logic [ADDR_W-1:0] wb_adr,
    input logic [63:0]       wb_dat,
    input logic [7:0]        wb_sel,
    input logic              wb_stall,
    input logic              wb_ack,
    input logic              cwr_en
);

    logic [7:0] unacked;

    always_ff @(posedge clk) begin
        if (rst) unacked <= '0;
        else     unacked <= unacked + 8'(wb_stb && !wb_stall) - 8'(wb_ack);
    end

    p_quiet_closed_r1: assert property (@(posedge clk) disable iff (rst)
        !wb_cyc |-> !wb_stb);

    p_hold_stalled_r2: assert property (@(posedge clk) disable iff (rst)
        (wb_stb && wb_stall) |=> (wb_stb && $stable(wb_adr) && $stable(wb_dat) && $stable(wb_sel)));

    p_zero_kept_out_r5: assert property (@(posedge clk) disable iff (rst)
        (st == ST_STORE && req_zero) |-> !req_ready);

    p_zero_beat_r6: assert property (@(posedge clk) disable iff (rst)
        (st == ST_ZERO && wb_stb) |-> (wb_sel == 8'hFF && wb_dat == 64'd0));

    p_zero_busy_r7: assert property (@(posedge clk) disable iff (rst)
        (st == ST_ZERO) |-> !req_ready);

    p_row_clear_r8: assert property (@(posedge clk) disable iff (rst)
        cwr_en |-> (st == ST_ZERO && wb_stb && !wb_stall));

    p_cyc_owed_r9: assert property (@(posedge clk) disable iff (rst)
        (unacked != 8'd0) |-> wb_cyc);

    p_window_r10: assert property (@(posedge clk) disable iff (rst)
        (st == ST_STORE) |-> (unacked <= 8'(MAX_OUT)));

endmodule

bind dcs_store_path dcs_store_path_chk #(.ADDR_W(ADDR_W), .MAX_OUT(MAX_OUT)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .st        (st),
    .req_zero  (req_zero),
    .req_ready (req_ready),
    .wb_cyc    (wb_cyc),
    .wb_stb    (wb_stb),
    .wb_adr    (wb_adr),
    .wb_dat    (wb_dat),
    .wb_sel    (wb_sel),
    .wb_stall  (wb_stall),
    .wb_ack    (wb_ack),
    .cwr_en    (cwr_en)
);

// File: tb/dcs_store_path_tb_top.sv
`timescale 1ns/1ps
module dcs_store_path_tb_top;

    localparam int AW = 10;
    localparam int LB = 3;
    localparam int SB = 3;
    localparam int MO = 4;
    localparam int ND = 1 << AW;
    localparam int NV = 12;

    typedef struct packed {
        logic          z;
        logic          h;
        logic [AW-1:0] a;
        logic [63:0]   d;
        logic [7:0]    s;
    } vec_t;

    // Tag = address bits [9:6]
    localparam vec_t VT [NV] = '{
        '{1'b0, 1'b0, 10'h041, 64'h1111_2222_3333_4444, 8'hFF},
        '{1'b0, 1'b0, 10'h047, 64'hAAAA_BBBB_CCCC_DDDD, 8'h0F},
        '{1'b0, 1'b0, 10'h07F, 64'h0123_4567_89AB_CDEF, 8'hF0},
        '{1'b1, 1'b1, 10'h043, 64'h0,                   8'h00},
        '{1'b0, 1'b0, 10'h045, 64'h5555_6666_7777_8888, 8'hFF},
        '{1'b0, 1'b0, 10'h081, 64'h9999_0000_9999_0000, 8'h3C},
        '{1'b0, 1'b0, 10'h0C0, 64'hFEDC_BA98_7654_3210, 8'hFF},
        '{1'b0, 1'b0, 10'h0C2, 64'h1357_9BDF_2468_ACE0, 8'h81},
        '{1'b1, 1'b0, 10'h0C5, 64'h0,                   8'h00},
        '{1'b1, 1'b1, 10'h0C8, 64'h0,                   8'h00},
        '{1'b0, 1'b0, 10'h3FF, 64'hDEAD_BEEF_0BAD_F00D, 8'hFF},
        '{1'b0, 1'b0, 10'h3C0, 64'hCAFE_0000_1234_5678, 8'hE7}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0, req_zero = 1'b0, req_hit = 1'b0;
    logic [AW-1:0] req_adr = '0;
    logic [63:0]   req_data = '0;
    logic [7:0]    req_sel = '0;
    logic          req_ready;
    logic          wb_cyc, wb_stb, wb_we;
    logic [AW-1:0] wb_adr;
    logic [63:0]   wb_dat;
    logic [7:0]    wb_sel;
    logic          wb_stall;
    logic          wb_ack;
    logic          cwr_en;
    logic [LB+SB-1:0] cwr_row;

    always #2.5 clk = ~clk;

    dcs_store_path #(.ADDR_W(AW), .LINE_BITS(LB), .SET_BITS(SB), .MAX_OUT(MO)) dut_i (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_zero(req_zero), .req_hit(req_hit),
        .req_adr(req_adr), .req_data(req_data), .req_sel(req_sel), .req_ready(req_ready),
        .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_we(wb_we), .wb_adr(wb_adr),
        .wb_dat(wb_dat), .wb_sel(wb_sel), .wb_stall(wb_stall), .wb_ack(wb_ack),
        .cwr_en(cwr_en), .cwr_row(cwr_row)
    );

    // ---------------- bus model ----------------
    logic [63:0] mem    [ND];
    logic [63:0] shadow [ND];
    logic        stall_rand = 1'b0, stall_force = 1'b0, ack_hold = 1'b0;
    logic [15:0] lfsr;
    int          pend;
    logic        take;

    always @(posedge clk) begin
        if (rst) begin
            wb_ack   <= 1'b0;
            wb_stall <= 1'b0;
            lfsr     <= 16'hACE1;
            pend     = 0;
            for (int i = 0; i < ND; i++) mem[i] <= 64'hC0DE_0000_0000_0000 + 64'(i);
        end else begin
            take = wb_cyc && wb_stb && !wb_stall;
            if (take)
                for (int b = 0; b < 8; b++)
                    if (wb_sel[b]) mem[wb_adr][8*b +: 8] <= wb_dat[8*b +: 8];
            pend = pend + (take ? 1 : 0) - (wb_ack ? 1 : 0);
            wb_ack   <= !ack_hold && (pend > 0);
            lfsr     <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            wb_stall <= stall_force || (stall_rand && lfsr[0] && lfsr[3]);
        end
    end

    // ---------------- monitor ----------------
    int          mon_checks = 0, mon_fails = 0;
    int          cyc_rises = 0, beats_cyc = 0, acks_cyc = 0, cwr_cnt = 0, row_err = 0;
    logic        cyc_q = 1'b0;
    logic [AW-1:0] last_adr;
    logic [63:0] last_dat;
    logic [7:0]  last_sel;
    logic        last_we;

    always @(negedge clk) begin
        if (!rst) begin
            if (wb_cyc && !cyc_q) cyc_rises++;
            if (wb_cyc && wb_stb && !wb_stall) begin
                beats_cyc++;
                last_adr = wb_adr; last_dat = wb_dat; last_sel = wb_sel; last_we = wb_we;
            end
            if (wb_ack) acks_cyc++;
            if (cwr_en) begin
                cwr_cnt++;
                if (cwr_row != wb_adr[LB+SB-1:0]) row_err++;
            end
            if (!wb_cyc && cyc_q) begin
                mon_checks++;
                if (acks_cyc != beats_cyc) begin
                    mon_fails++;
                    $display("FAIL R9 cycle closed with acks %0d expected %0d", acks_cyc, beats_cyc);
                end
                acks_cyc = 0; beats_cyc = 0;
            end
            cyc_q = wb_cyc;
        end
    end

    // ---------------- checking helpers ----------------
    int checks = 0, fails = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic summary(input int extra);
        $display("== %0d vectors applied, %0d miscompares ==",
                 checks + mon_checks + extra, fails + mon_fails + extra);
    endtask

    function automatic void shadow_apply(input logic z, input logic [AW-1:0] a,
                                         input logic [63:0] d, input logic [7:0] s);
        if (z) begin
            for (int k = 0; k < (1 << LB); k++) shadow[{a[AW-1:LB], LB'(k)}] = 64'd0;
        end else begin
            for (int b = 0; b < 8; b++) if (s[b]) shadow[a][8*b +: 8] = d[8*b +: 8];
        end
    endfunction

    // Called at a negedge; returns at a negedge.
    task automatic send(input logic z, input logic h, input logic [AW-1:0] a,
                        input logic [63:0] d, input logic [7:0] s,
                        input int limit, output bit taken);
        taken = 1'b0;
        req_valid = 1'b1; req_zero = z; req_hit = h; req_adr = a; req_data = d; req_sel = s;
        for (int n = 0; n < limit && !taken; n++) begin
            #1;
            if (req_ready) taken = 1'b1;
            @(negedge clk);
        end
        req_valid = 1'b0; req_zero = 1'b0; req_hit = 1'b0;
        if (taken) shadow_apply(z, a, d, s);
    endtask

    task automatic wait_idle();
        int quiet = 0;
        for (int n = 0; n < 3000 && quiet < 3; n++) begin
            @(negedge clk);
            if (!wb_cyc) quiet++; else quiet = 0;
        end
    endtask

    task automatic compare_line(input logic [AW-1:0] a, input string req);
        bit ok = 1'b1;
        logic [63:0] act = '0, exp = '0;
        for (int k = 0; k < (1 << LB); k++) begin
            if (ok && mem[{a[AW-1:LB], LB'(k)}] !== shadow[{a[AW-1:LB], LB'(k)}]) begin
                ok = 1'b0;
                act = mem[{a[AW-1:LB], LB'(k)}];
                exp = shadow[{a[AW-1:LB], LB'(k)}];
            end
        end
        check(ok, req, $sformatf("memory line at %h", a), act, exp);
    endtask

    // ---------------- watchdog ----------------
    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            $display("FAIL watchdog expired: got %0d cycles expected fewer", wd);
            summary(1);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        bit tk;
        int base_rises, exp_new, hits, took;
        logic [AW-TAG_LSB_TB()-1:0] prev_tag;
        logic prev_z;

        for (int i = 0; i < ND; i++) shadow[i] = 64'hC0DE_0000_0000_0000 + 64'(i);

        repeat (4) @(negedge clk);
        // R1: reset state
        check(!wb_cyc && !wb_stb, "R1", "cyc/stb during reset", {62'd0, wb_cyc, wb_stb}, 64'd0);
        check(req_ready === 1'b1, "R1", "ready during reset", 64'(req_ready), 64'd1);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check(!wb_cyc && req_ready, "R1", "idle after reset", {62'd0, wb_cyc, req_ready}, 64'd1);

        // ---- vector table with random stalls ----
        stall_rand = 1'b1;
        base_rises = cyc_rises;
        exp_new = 0; hits = 0;
        prev_tag = '0; prev_z = 1'b0;
        for (int v = 0; v < NV; v++) begin
            if (v == 0 || VT[v].z || prev_z || VT[v].a[AW-1:LB+SB] != prev_tag) exp_new++;
            if (VT[v].z && VT[v].h) hits++;
            prev_tag = VT[v].a[AW-1:LB+SB];
            prev_z   = VT[v].z;
            send(VT[v].z, VT[v].h, VT[v].a, VT[v].d, VT[v].s, 400, tk);
            check(tk, VT[v].z ? "R7" : "R3", $sformatf("vector %0d accepted", v), 64'(tk), 64'd1);
        end
        wait_idle();
        // R3 joins, R4 tag change and R5 zero separation set the cycle count
        check(cyc_rises - base_rises == exp_new, "R5", "bus cycles for table",
              64'(cyc_rises - base_rises), 64'(exp_new));
        for (int v = 0; v < NV; v++) compare_line(VT[v].a, VT[v].z ? "R6" : "R2");
        check(cwr_cnt == 8 * hits && row_err == 0, "R8", "cache row clears",
              64'(cwr_cnt), 64'(8 * hits));
        stall_rand = 1'b0;

        // ---- R2: single store fields ----
        send(1'b0, 1'b0, 10'h200, 64'h0F1E_2D3C_4B5A_6978, 8'h3C, 50, tk);
        wait_idle();
        check(last_adr == 10'h200 && last_we, "R2", "store address", 64'(last_adr), 64'h200);
        check(last_dat == 64'h0F1E_2D3C_4B5A_6978, "R2", "store data", last_dat, 64'h0F1E_2D3C_4B5A_6978);
        check(last_sel == 8'h3C, "R2", "store enables", 64'(last_sel), 64'h3C);

        // ---- R4 / R5: refused while batch open ----
        stall_force = 1'b1;
        @(negedge clk);
        base_rises = cyc_rises;
        send(1'b0, 1'b0, 10'h210, 64'h1, 8'hFF, 5, tk);
        req_valid = 1'b1; req_zero = 1'b0; req_adr = 10'h300; req_sel = 8'hFF; req_data = 64'h2;
        #1;
        check(req_ready == 1'b0, "R4", "ready for other tag", 64'(req_ready), 64'd0);
        req_zero = 1'b1; req_adr = 10'h211;
        #1;
        check(req_ready == 1'b0, "R5", "ready for same-tag zero", 64'(req_ready), 64'd0);
        req_valid = 1'b0; req_zero = 1'b0;
        @(negedge clk);
        stall_force = 1'b0;
        send(1'b0, 1'b0, 10'h300, 64'h2, 8'hFF, 50, tk);
        wait_idle();
        check(cyc_rises - base_rises == 2, "R4", "separate bus cycles", 64'(cyc_rises - base_rises), 64'd2);
        compare_line(10'h300, "R4");

        // ---- R10: in-flight limit with acks withheld ----
        ack_hold = 1'b1;
        took = 0;
        for (int k = 0; k < MO + 2; k++) begin
            send(1'b0, 1'b0, AW'(10'h280 + k), 64'hA000 + 64'(k), 8'hFF, 6, tk);
            if (tk) took++;
        end
        check(took == MO, "R10", "stores accepted without acks", 64'(took), 64'(MO));
        check(wb_cyc == 1'b1, "R9", "cycle held while owed", 64'(wb_cyc), 64'd1);
        ack_hold = 1'b0;
        wait_idle();
        compare_line(10'h280, "R10");

        // ---- R7 / R8: zeroing waits for acks ----
        ack_hold = 1'b1;
        hits = cwr_cnt;
        send(1'b1, 1'b1, 10'h18B, 64'd0, 8'd0, 5, tk);
        repeat (12) @(negedge clk);
        check(wb_cyc == 1'b1, "R7", "zeroing open without acks", 64'(wb_cyc), 64'd1);
        req_valid = 1'b1; req_zero = 1'b0; req_adr = 10'h188; req_sel = 8'hFF;
        #1;
        check(req_ready == 1'b0, "R7", "ready during zeroing", 64'(req_ready), 64'd0);
        req_valid = 1'b0;
        ack_hold = 1'b0;
        wait_idle();
        compare_line(10'h188, "R6");
        check(cwr_cnt - hits == 8 && row_err == 0, "R8", "rows cleared on hit",
              64'(cwr_cnt - hits), 64'd8);

        summary(0);
        $finish;
    end

    function automatic int TAG_LSB_TB();
        return LB + SB;
    endfunction

endmodule